// File: doc/BRIEF.md
# Transmit Command-Word Packet Loader

This block is the host side of a transmit path built on first-in first-out storage. The host writes 32-bit words into one data port. Each buffer it writes starts with two control words and continues with payload words. The control words say where the useful bytes sit inside the payload words, whether the buffer opens or closes a packet, and which tag and total length the packet carries. The block stores the raw words in a data FIFO and reports the free space in bytes. A read-side engine parses the control words and sends the useful bytes out on a byte-wide stream with valid/ready/last handshaking. When a packet ends, the engine writes one status word into a status FIFO, which the host can peek or pop.

Software keeps the words in step by checking free space before it writes a buffer. It needs room for the rounded payload plus 8 bytes for the two control words. A write that finds the data FIFO full is discarded and recorded in a sticky flag. Each FIFO can be flushed on its own. Sending starts only while transmission is enabled.

Top module: `txcw_loader`

## Requirements
- R1: After reset, `fifo_info[15:0]` shows `DATA_DEPTH*4` free bytes and `fifo_info[23:16]` shows 0 status entries. Every accepted write to the data port lowers the free count by 4.
- R2: A data write made while the data FIFO is full is discarded and sets `overrun`. The flag stays set until the data FIFO is flushed.
- R3: In the first control word, bits 10:0 hold the byte count and bits 20:16 the start offset. Bit 13 marks the first segment and bit 12 the last. Bits 25:24 select the end alignment: 0 gives 4 bytes, 1 gives 16, 2 gives 32, 3 gives 64. A buffer consumes offset+count rounded up to that alignment, divided by 4 payload words, after the two control words.
- R4: Payload bytes leave in little-endian order within each word (bits 7:0 first). The `offset` leading bytes are skipped and exactly `count` bytes are emitted.
- R5: `m_tlast` is high only with the final emitted byte of a buffer whose last-segment bit is set.
- R6: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R7: While `tx_en` is low, the engine starts no new buffer and consumes nothing from the data FIFO.
- R8: At the end of each last-segment buffer, one status word is pushed. Bits 31:16 hold the tag from bits 31:16 of the second control word. Bit 15 is set when the counts summed since the first-segment buffer differ from the packet length in bits 10:0 of the second control word. All other bits are 0. `fifo_info[23:16]` counts the stored entries.
- R9: `sts_head` shows the oldest status entry without removing it. A one-cycle `sts_pop` removes that entry.
- R10: `flush_sts` empties the status FIFO. `flush_data` empties the data FIFO, abandons the buffer in progress and clears `overrun`.
- R11: Bits 14:12 of the second control word (checksum, no-CRC and no-padding requests) do not change the emitted bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the data port |
| wr_data | input | 32 | Control or payload word |
| tx_en | input | 1 | Transmission enable |
| flush_data | input | 1 | Flush data FIFO (one-cycle pulse) |
| flush_sts | input | 1 | Flush status FIFO (one-cycle pulse) |
| fifo_info | output | 32 | [15:0] free data bytes, [23:16] used status entries |
| overrun | output | 1 | Sticky data-port overrun flag |
| sts_head | output | 32 | Oldest status entry (peek) |
| sts_pop | input | 1 | Remove oldest status entry |
| m_tdata | output | 8 | Stream byte |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tlast | output | 1 | Final byte of packet |

## Verification
A wrong parse state shows up quickly. If the engine loses track of which word is a control word, it reads payload as a header. Within the next buffer or two it then emits bytes that do not match, puts `m_tlast` in the wrong place, or leaves a nonzero word count in the data FIFO after traffic drains. A wrong rounding of the buffer span produces the same symptoms, so the free-byte field is compared with the full depth once the queue drains. Errors in the length accumulator or tag latch appear only in the status word, one pop after the packet closes. The pops are therefore checked against an independently kept per-packet sum.

// File: rtl/txcw_pkg.sv
package txcw_pkg;

  typedef enum logic [1:0] {
    ST_CMDA = 2'd0,
    ST_CMDB = 2'd1,
    ST_PAY  = 2'd2,
    ST_DONE = 2'd3
  } eng_state_t;

  function automatic logic [10:0] ctl_count(input logic [31:0] a);
    return a[10:0];
  endfunction

  function automatic logic [4:0] ctl_offset(input logic [31:0] a);
    return a[20:16];
  endfunction

  function automatic logic ctl_first(input logic [31:0] a);
    return a[13];
  endfunction

  function automatic logic ctl_last(input logic [31:0] a);
    return a[12];
  endfunction

  // payload words a buffer occupies: (offset+count) rounded to the alignment granule
  function automatic logic [10:0] span_words(input logic [31:0] a);
    logic [12:0] raw;
    logic [12:0] msk;
    logic [12:0] rnd;
    raw = 13'(a[20:16]) + 13'(a[10:0]);
    case (a[25:24])
      2'd0:    msk = 13'd3;
      2'd1:    msk = 13'd15;
      2'd2:    msk = 13'd31;
      default: msk = 13'd63;
    endcase
    rnd = (raw + msk) & ~msk;
    return rnd[12:2];
  endfunction

endpackage

// File: rtl/txcw_fifo.sv
module txcw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/txcw_engine.sv
module txcw_engine
  import txcw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        abort,
  input  logic        tx_en,
  input  logic [31:0] head,
  input  logic        empty,
  output logic        pop,
  output logic [7:0]  m_tdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic        m_tlast,
  input  logic        sts_full,
  output logic        sts_push,
  output logic [31:0] sts_word,
  output logic        idle
);
  eng_state_t  state;
  logic [31:0] cmd_a;
  logic [15:0] tag;
  logic [10:0] pkt_len;
  logic [10:0] words_left;
  logic [12:0] byte_idx;
  logic [15:0] acc;

  logic [12:0] first_b, end_b;
  logic [1:0]  lane;
  logic        in_range, step, is_last;

  assign lane     = byte_idx[1:0];
  assign first_b  = 13'(ctl_offset(cmd_a));
  assign end_b    = first_b + 13'(ctl_count(cmd_a));
  assign in_range = (byte_idx >= first_b) && (byte_idx < end_b);
  assign is_last  = ctl_last(cmd_a);

  assign m_tvalid = (state == ST_PAY) && !empty && in_range;
  assign m_tdata  = head[8*lane +: 8];
  assign m_tlast  = m_tvalid && is_last && (byte_idx == end_b - 13'd1);
  assign step     = (state == ST_PAY) && !empty && (!in_range || m_tready);

  assign pop = ((state == ST_CMDA) && tx_en && !empty) ||
               ((state == ST_CMDB) && !empty) ||
               (step && (lane == 2'd3));

  assign sts_word = {tag, (acc != 16'(pkt_len)), 15'd0};
  assign sts_push = (state == ST_DONE) && is_last && !sts_full && !abort;
  assign idle     = (state == ST_CMDA);

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      state      <= ST_CMDA;
      cmd_a      <= '0;
      tag        <= '0;
      pkt_len    <= '0;
      words_left <= '0;
      byte_idx   <= '0;
      acc        <= '0;
    end else begin
      case (state)
        ST_CMDA: if (tx_en && !empty) begin
          cmd_a <= head;
          state <= ST_CMDB;
        end
        ST_CMDB: if (!empty) begin
          tag        <= head[31:16];
          pkt_len    <= head[10:0];
          acc        <= ctl_first(cmd_a) ? 16'(ctl_count(cmd_a))
                                         : acc + 16'(ctl_count(cmd_a));
          words_left <= span_words(cmd_a);
          byte_idx   <= '0;
          state      <= (span_words(cmd_a) == '0) ? ST_DONE : ST_PAY;
        end
        ST_PAY: if (step) begin
          byte_idx <= byte_idx + 13'd1;
          if (lane == 2'd3) begin
            words_left <= words_left - 11'd1;
            if (words_left == 11'd1) state <= ST_DONE;
          end
        end
        default: if (!is_last || !sts_full) state <= ST_CMDA;
      endcase
    end
  end
endmodule

// File: rtl/txcw_loader.sv
module txcw_loader #(
  parameter int DATA_DEPTH = 64,
  parameter int STS_DEPTH  = 16,
  localparam int DCW       = $clog2(DATA_DEPTH + 1),
  localparam int SCW       = $clog2(STS_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        tx_en,
  input  logic        flush_data,
  input  logic        flush_sts,
  output logic [31:0] fifo_info,
  output logic        overrun,
  output logic [31:0] sts_head,
  input  logic        sts_pop,
  output logic [7:0]  m_tdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic        m_tlast
);
  logic [DCW-1:0] dcount;
  logic [SCW-1:0] scount;
  logic [31:0]    dhead;
  logic           data_full, data_push, data_pop, ovr_evt;
  logic           sts_push, sts_full, eng_idle;
  logic [31:0]    sts_word;
  logic [DCW-1:0] free_words;

  assign data_full  = (dcount == DCW'(DATA_DEPTH));
  assign data_push  = wr_en && !data_full && !flush_data;
  assign ovr_evt    = wr_en && data_full && !flush_data;
  assign sts_full   = (scount == SCW'(STS_DEPTH));
  assign free_words = DCW'(DATA_DEPTH) - dcount;
  assign fifo_info  = {8'd0, 8'(scount), 16'(free_words) << 2};

  always_ff @(posedge clk) begin
    if (!rst_n || flush_data) overrun <= 1'b0;
    else if (ovr_evt)         overrun <= 1'b1;
  end

  txcw_fifo #(.W(32), .DEPTH(DATA_DEPTH)) u_data (
    .clk(clk), .rst_n(rst_n), .flush(flush_data),
    .push(data_push), .din(wr_data),
    .pop(data_pop), .dout(dhead), .count(dcount)
  );

  txcw_fifo #(.W(32), .DEPTH(STS_DEPTH)) u_sts (
    .clk(clk), .rst_n(rst_n), .flush(flush_sts),
    .push(sts_push), .din(sts_word),
    .pop(sts_pop), .dout(sts_head), .count(scount)
  );

  txcw_engine u_eng (
    .clk(clk), .rst_n(rst_n), .abort(flush_data), .tx_en(tx_en),
    .head(dhead), .empty(dcount == '0), .pop(data_pop),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
    .sts_full(sts_full), .sts_push(sts_push), .sts_word(sts_word), .idle(eng_idle)
  );
endmodule

// File: rtl/txcw_loader_checks.sv
module txcw_loader_checks #(
  parameter int DATA_DEPTH = 64,
  parameter int STS_DEPTH  = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_en,
  input logic        flush_data,
  input logic        flush_sts,
  input logic [31:0] fifo_info,
  input logic        overrun,
  input logic [31:0] sts_head,
  input logic        sts_pop,
  input logic [7:0]  m_tdata,
  input logic        m_tvalid,
  input logic        m_tready,
  input logic        m_tlast,
  input logic        ovr_evt,
  input logic        eng_idle
);
  assert_free_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_info[15:0]) <= DATA_DEPTH * 4);

  assert_overrun_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> overrun);

  assert_overrun_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !flush_data) |=> overrun);

  assert_tlast_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |-> m_tvalid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready && !flush_data) |=>
      (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle && !tx_en) |=> eng_idle);

  assert_sts_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_info[23:16]) <= STS_DEPTH);

  assert_peek_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_pop && !flush_sts && fifo_info[23:16] != 8'd0) |=> $stable(sts_head));

  assert_flush_sts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_sts |=> (fifo_info[23:16] == 8'd0));

  assert_flush_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_data |=> (int'(fifo_info[15:0]) == DATA_DEPTH * 4 && !overrun));
endmodule

bind txcw_loader txcw_loader_checks #(.DATA_DEPTH(DATA_DEPTH), .STS_DEPTH(STS_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .flush_data(flush_data), .flush_sts(flush_sts),
  .fifo_info(fifo_info), .overrun(overrun), .sts_head(sts_head), .sts_pop(sts_pop),
  .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
  .ovr_evt(ovr_evt), .eng_idle(eng_idle)
);

// File: tb/txcw_loader_bench.sv
module txcw_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tx_en = 1'b0;
  logic        flush_data = 1'b0;
  logic        flush_sts = 1'b0;
  logic [31:0] fifo_info;
  logic        overrun;
  logic [31:0] sts_head;
  logic        sts_pop = 1'b0;
  logic [7:0]  m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b0;
  logic        m_tlast;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [8:0]  exp_q[$];
  logic [31:0] exp_sts[$];
  int          pkt_sum;
  bit          pend;
  logic [8:0]  pend_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  txcw_loader u_txcw_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tx_en(tx_en),
    .flush_data(flush_data), .flush_sts(flush_sts), .fifo_info(fifo_info),
    .overrun(overrun), .sts_head(sts_head), .sts_pop(sts_pop),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // granule in bytes, then whole words
  function automatic int words_for(input int off, input int cnt, input int algn);
    int g;
    g = (algn == 0) ? 4 : (8 << algn);
    return ((off + cnt + g - 1) / g) * (g / 4);
  endfunction

  // stream monitor: choose ready, then judge the transfer at the next edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend)
        chk(m_tvalid && {m_tlast, m_tdata} == pend_val, "R6 hold", {m_tvalid, m_tlast, m_tdata}, {1'b1, pend_val});
      m_tready = ($urandom % 10) < 7;
      pend = m_tvalid && !m_tready;
      pend_val = {m_tlast, m_tdata};
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R4 unexpected byte", {23'd0, m_tlast, m_tdata}, 32'd0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(m_tdata == e[7:0], "R4 byte", m_tdata, e[7:0]);
          chk(m_tlast == e[8], "R5 tlast", m_tlast, e[8]);
        end
      end
    end else pend = 1'b0;
  end

  task automatic put_words(input logic [31:0] w[$]);
    foreach (w[i]) begin
      wr_en = 1'b1;
      wr_data = w[i];
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic send_buf(input int off, input int cnt, input int algn, input bit first, input bit last,
                          input logic [15:0] tag, input int plen, input logic [2:0] flg);
    logic [31:0] w[$];
    logic [31:0] a, b;
    int nw, st;
    nw = words_for(off, cnt, algn);
    a = '0;
    a[31] = $urandom % 2;
    a[25:24] = 2'(algn);
    a[20:16] = 5'(off);
    a[13] = first;
    a[12] = last;
    a[10:0] = 11'(cnt);
    b = '0;
    b[31:16] = tag;
    b[14:12] = flg;
    b[10:0] = 11'(plen);
    w.push_back(a);
    w.push_back(b);
    for (int i = 0; i < nw; i++) begin
      logic [31:0] d;
      d = $urandom;
      w.push_back(d);
      for (int k = 0; k < 4; k++) begin
        int p;
        p = i * 4 + k;
        if (p >= off && p < off + cnt)
          exp_q.push_back({(last && p == off + cnt - 1), d[8*k +: 8]});
      end
    end
    pkt_sum = first ? cnt : pkt_sum + cnt;
    if (last) exp_sts.push_back({tag, (pkt_sum != plen), 15'd0});
    st = cyc;
    while (int'(fifo_info[15:0]) < (nw + 2) * 4 && cyc - st < 20000) @(negedge clk);
    put_words(w);
  endtask

  task automatic drain();
    int st;
    st = cyc;
    while ((exp_q.size() != 0 || int'(fifo_info[15:0]) != DEPTH * 4) && cyc - st < 20000)
      @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_one();
    logic [31:0] e;
    e = (exp_sts.size() != 0) ? exp_sts.pop_front() : 32'hxxxxxxxx;
    chk(sts_head === e, "R8 status word", sts_head, e);
    sts_pop = 1'b1;
    @(negedge clk);
    sts_pop = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_info == 32'(DEPTH * 4), "R1 reset info", fifo_info, 32'(DEPTH * 4));
    chk(!m_tvalid && !overrun, "R1 reset outputs", {m_tvalid, overrun}, 0);

    // disabled transmitter: words stay put
    begin
      logic [31:0] w[$];
      for (int i = 0; i < 3; i++) w.push_back(32'h0000_1004);
      put_words(w);
    end
    chk(fifo_info[15:0] == 16'(DEPTH * 4 - 12), "R1 free after 3 writes", fifo_info[15:0], DEPTH * 4 - 12);
    repeat (6) @(negedge clk);
    chk(fifo_info[15:0] == 16'(DEPTH * 4 - 12), "R7 nothing consumed while disabled", fifo_info[15:0], DEPTH * 4 - 12);
    begin
      logic [31:0] w[$];
      for (int i = 0; i < DEPTH - 3; i++) w.push_back(32'hA5A5_0000 + i);
      put_words(w);
    end
    chk(fifo_info[15:0] == 16'd0 && !overrun, "R2 full without overrun", {overrun, fifo_info[15:0]}, 0);
    begin
      logic [31:0] w[$];
      w.push_back(32'hDEAD_BEEF);
      put_words(w);
    end
    chk(overrun == 1'b1, "R2 overrun set", overrun, 1);
    chk(fifo_info[15:0] == 16'd0, "R2 extra word discarded", fifo_info[15:0], 0);
    repeat (3) @(negedge clk);
    chk(overrun == 1'b1, "R2 overrun sticky", overrun, 1);
    flush_data = 1'b1;
    @(negedge clk);
    flush_data = 1'b0;
    chk(fifo_info[15:0] == 16'(DEPTH * 4) && !overrun, "R10 data flush", {overrun, fifo_info[15:0]}, DEPTH * 4);

    // directed buffers
    tx_en = 1'b1;
    send_buf(2, 5, 0, 1, 1, 16'hBEEF, 5, 3'b000);
    send_buf(3, 6, 2, 1, 1, 16'h1234, 6, 3'b000);
    drain();
    chk(fifo_info[15:0] == 16'(DEPTH * 4), "R3 aligned span fully consumed", fifo_info[15:0], DEPTH * 4);
    send_buf(0, 7, 1, 1, 0, 16'h0001, 0, 3'b000);
    send_buf(1, 4, 0, 0, 0, 16'h0002, 0, 3'b000);
    send_buf(31, 9, 3, 0, 1, 16'hC0DE, 20, 3'b000);
    send_buf(0, 8, 0, 1, 1, 16'h7777, 9, 3'b000);
    send_buf(1, 11, 0, 1, 1, 16'h5A5A, 11, 3'b111);  // R11 flags set
    drain();
    chk(exp_q.size() == 0, "R4 all directed bytes seen", exp_q.size(), 0);
    chk(fifo_info[23:16] == 8'd5, "R8 status count", fifo_info[23:16], 5);
    begin
      logic [31:0] h0;
      h0 = sts_head;
      repeat (2) @(negedge clk);
      chk(sts_head == h0 && fifo_info[23:16] == 8'd5, "R9 peek non-destructive", sts_head, h0);
    end
    while (fifo_info[23:16] != 8'd0 && exp_sts.size() != 0) pop_one();
    chk(fifo_info[23:16] == 8'd0, "R9 pops emptied status", fifo_info[23:16], 0);

    send_buf(0, 4, 0, 1, 1, 16'h0A0A, 4, 3'b000);
    send_buf(0, 4, 0, 1, 1, 16'h0B0B, 4, 3'b000);
    drain();
    chk(fifo_info[23:16] == 8'd2, "R8 two statuses", fifo_info[23:16], 2);
    flush_sts = 1'b1;
    @(negedge clk);
    flush_sts = 1'b0;
    chk(fifo_info[23:16] == 8'd0, "R10 status flush", fifo_info[23:16], 0);
    exp_sts.delete();

    // random packets
    for (int p = 0; p < 40; p++) begin
      int nb, tot, plen;
      logic [15:0] tg;
      int offs[3], cnts[3], als[3];
      nb = 1 + ($urandom % 3);
      tot = 0;
      for (int k = 0; k < nb; k++) begin
        offs[k] = $urandom % 32;
        cnts[k] = 1 + ($urandom % 60);
        als[k] = $urandom % 4;
        tot += cnts[k];
      end
      tg = 16'($urandom);
      plen = (($urandom % 4) == 0) ? tot + 1 : tot;
      for (int k = 0; k < nb; k++)
        send_buf(offs[k], cnts[k], als[k], k == 0, k == nb - 1, tg, plen, 3'($urandom));
      while (fifo_info[23:16] != 8'd0 && exp_sts.size() != 0) pop_one();
    end
    drain();
    while (fifo_info[23:16] != 8'd0 && exp_sts.size() != 0) pop_one();
    chk(exp_q.size() == 0, "R4 random bytes all delivered", exp_q.size(), 0);
    chk(exp_sts.size() == 0, "R8 random statuses all seen", exp_sts.size(), 0);
    chk(fifo_info[15:0] == 16'(DEPTH * 4), "R3 random spans consumed", fifo_info[15:0], DEPTH * 4);
    finish_run();
  end
endmodule